// File: doc/BRIEF.md
# Serial Link Word Aligner

This block takes a raw bit-serial stream from a front-end digitizer and turns it into aligned words. The bit sampling point has already been tuned upstream, but the word boundary is unknown. One clock edge carries one serial bit. Every word of W bits spans one bunch-clock period. W is 8, 16 or 32 and follows the selected line rate.

The boundary is found from a marker that the transmitter sends after a bunch-crossing-zero synchronization pulse. The marker is one word of zeros, then one word of ones, then one word of zeros. The sync pulse and the sampling clock share the same skew, so the marker lines up directly with the sampled bits and no extra offset is applied.

A sync pulse opens a search over a bounded number of bits. The first exact marker match in that search fixes a candidate bit offset. A second match at the same offset declares lock. While locked, the block emits one aligned word per word period together with a one-cycle valid strobe. A match at any other offset drops lock and increments a saturating loss counter.

Top module: `link_word_aligner`

## Requirements
- R1: A synchronous reset clears lock, valid and the loss counter, and the block starts searching with its word phase at zero.
- R2: `rateSel` picks the word width W: 0 gives 8 bits, 1 gives 16 bits, 2 and 3 give 32 bits.
- R3: The marker is recognised only when the last 3W received bits are W zeros, then W ones, then W zeros, in arrival order. The bit offset of the match is the number of bits received since the last clear, modulo W, counted when the last zero arrives.
- R4: Lock asserts only after two successive marker matches at the same offset. A single match never asserts lock.
- R5: While locked, a match at a different offset drops lock on the following edge and increments the loss counter. That new offset becomes the candidate, and one more match at it restores lock.
- R6: While locked, `validOut` pulses for exactly one clock in every W clocks, and never while unlocked. `dataOut` holds the last W bits received, with the earliest bit in bit W-1 and the bits above W-1 at zero.
- R7: Any change of `rateSel` drops lock on the next edge and clears the search state and word phase, and leaves the loss counter unchanged. Two fresh matches are then needed to lock again.
- R8: The loss counter stops at its maximum value (all ones) and does not wrap.
- R9: A marker that completes more than SEARCH_BITS bits after the last sampled sync pulse is ignored. Lock state and loss count stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, one bit per edge |
| rst | input | 1 | Synchronous active-high reset |
| serIn | input | 1 | Sampled serial data bit |
| syncIn | input | 1 | Bunch-crossing-zero pulse that opens a marker search |
| rateSel | input | 2 | Line rate select; sets word width |
| dataOut | output | 32 | Aligned word, right-justified |
| validOut | output | 1 | One-cycle strobe per aligned word |
| lockOut | output | 1 | Word boundary locked |
| lossCount | output | LOSS_W | Saturating count of lock losses |

## Verification
Any internal fault in this block shows up at the ports as a wrong lock flag, a valid pulse that appears or goes missing, or a word shifted by some number of bits.

- A corrupted offset or phase register shows up within one word period, as a strobe that is early or late or a word that is rotated.
- A fault in the state machine shows up on the edge after the second marker, or after the conflicting one, as a wrong lock flag or loss count.
- A window counter that stops too early or too late shows up as lock that appears or disappears after a marker the bench placed deliberately inside or outside the search span.

// File: rtl/lwa_pkg.sv
package lwa_pkg;
  localparam int MAX_W = 32;
  localparam int HIST_W = 3 * MAX_W;
  localparam int PH_W = $clog2(MAX_W);

  typedef struct packed {
    logic clear;
    logic emit;
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } lockState_t;

  function automatic logic [1:0] rateIdx(input logic [1:0] rate);
    return (rate == 2'd3) ? 2'd2 : rate;
  endfunction

  function automatic logic [PH_W-1:0] lastIdx(input logic [1:0] rate);
    case (rateIdx(rate))
      2'd0:    return PH_W'(7);
      2'd1:    return PH_W'(15);
      default: return PH_W'(31);
    endcase
  endfunction
endpackage

// File: rtl/lwa_datapath.sv
module lwa_datapath
  import lwa_pkg::*;
#(
  parameter int SEARCH_BITS = 160
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                serIn,
  input  logic                syncIn,
  input  logic [1:0]          rateQ,
  input  ctlStrobe_t          ctl,
  output logic                matchHit,
  output logic [PH_W-1:0]     phase,
  output logic [MAX_W-1:0]    dataOut,
  output logic                validOut
);
  localparam int WIN_W = $clog2(SEARCH_BITS + 1);

  logic [HIST_W-1:0] hist;
  logic [WIN_W-1:0]  winCnt;
  logic [2:0]        hitVec;
  logic [MAX_W-1:0]  wordVec [3];
  logic [1:0]        sel;

  for (genvar g = 0; g < 3; g++) begin : g_width
    localparam int W = 8 << g;
    localparam logic [MAX_W-1:0] MASK = {MAX_W{1'b1}} >> (MAX_W - W);
    assign hitVec[g] = (hist[W-1:0] == '0) && (hist[2*W-1:W] == '1) &&
                       (hist[3*W-1:2*W] == '0);
    assign wordVec[g] = hist[MAX_W-1:0] & MASK;
  end

  assign sel      = rateIdx(rateQ);
  assign matchHit = (winCnt != '0) && hitVec[sel];

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) begin
      hist     <= '0;
      phase    <= '0;
      winCnt   <= '0;
      validOut <= 1'b0;
      dataOut  <= '0;
    end else begin
      hist     <= {hist[HIST_W-2:0], serIn};
      phase    <= (phase == lastIdx(rateQ)) ? '0 : phase + 1'b1;
      validOut <= ctl.emit;
      if (ctl.emit) dataOut <= wordVec[sel];
      if (syncIn)                winCnt <= WIN_W'(SEARCH_BITS);
      else if (matchHit)         winCnt <= '0;
      else if (winCnt != '0)     winCnt <= winCnt - 1'b1;
    end
  end
endmodule

// File: rtl/lwa_control.sv
module lwa_control
  import lwa_pkg::*;
#(
  parameter int LOSS_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        rateSel,
  input  logic              matchHit,
  input  logic [PH_W-1:0]   phase,
  output ctlStrobe_t        ctl,
  output logic [1:0]        rateQ,
  output logic              lockOut,
  output logic [LOSS_W-1:0] lossCount
);
  lockState_t      state;
  logic [PH_W-1:0] offset;
  logic            rateChg;

  assign rateChg   = (rateSel != rateQ);
  assign lockOut   = (state == ST_LOCKED);
  assign ctl.clear = rateChg;
  assign ctl.emit  = lockOut && (phase == offset) && !rateChg;

  always_ff @(posedge clk) begin
    rateQ <= rateSel;
    if (rst) begin
      state     <= ST_SEARCH;
      offset    <= '0;
      lossCount <= '0;
    end else if (rateChg) begin
      state <= ST_SEARCH;
    end else if (matchHit) begin
      case (state)
        ST_SEARCH: begin
          offset <= phase;
          state  <= ST_CONFIRM;
        end
        ST_CONFIRM: begin
          if (phase == offset) state <= ST_LOCKED;
          else offset <= phase;
        end
        default: begin
          if (phase != offset) begin
            state  <= ST_CONFIRM;
            offset <= phase;
            if (lossCount != '1) lossCount <= lossCount + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/link_word_aligner.sv
module link_word_aligner
  import lwa_pkg::*;
#(
  parameter int SEARCH_BITS = 160,
  parameter int LOSS_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serIn,
  input  logic              syncIn,
  input  logic [1:0]        rateSel,
  output logic [31:0]       dataOut,
  output logic              validOut,
  output logic              lockOut,
  output logic [LOSS_W-1:0] lossCount
);
  ctlStrobe_t      ctl;
  logic            matchHit;
  logic [PH_W-1:0] phase;
  logic [1:0]      rateQ;

  lwa_datapath #(.SEARCH_BITS(SEARCH_BITS)) u_dp (
    .clk(clk), .rst(rst), .serIn(serIn), .syncIn(syncIn), .rateQ(rateQ),
    .ctl(ctl), .matchHit(matchHit), .phase(phase), .dataOut(dataOut),
    .validOut(validOut)
  );

  lwa_control #(.LOSS_W(LOSS_W)) u_ctl (
    .clk(clk), .rst(rst), .rateSel(rateSel), .matchHit(matchHit),
    .phase(phase), .ctl(ctl), .rateQ(rateQ), .lockOut(lockOut),
    .lossCount(lossCount)
  );
endmodule

// File: rtl/lwa_checker.sv
module lwa_checker #(
  parameter int LOSS_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        rateSel,
  input logic              matchHit,
  input logic              lockOut,
  input logic              validOut,
  input logic [LOSS_W-1:0] lossCount
);
  p_valid_needs_lock_r6: assert property (@(posedge clk) disable iff (rst)
    validOut |-> $past(lockOut));

  p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
    validOut |=> !validOut);

  p_lock_after_match_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(lockOut) |-> $past(matchHit));

  p_rate_unlock_r7: assert property (@(posedge clk) disable iff (rst)
    (rateSel != $past(rateSel)) |=> !lockOut);

  p_loss_step_r5: assert property (@(posedge clk) disable iff (rst)
    (lossCount != $past(lossCount)) |->
      ((lossCount == LOSS_W'($past(lossCount) + 1'b1)) && $fell(lockOut)));

  p_loss_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    lossCount >= $past(lossCount));
endmodule

bind link_word_aligner lwa_checker #(.LOSS_W(LOSS_W)) u_chk (
  .clk(clk), .rst(rst), .rateSel(rateSel), .matchHit(matchHit),
  .lockOut(lockOut), .validOut(validOut), .lossCount(lossCount)
);

// File: tb/link_word_aligner_bench.sv
module link_word_aligner_bench;
  localparam int SEARCH = 160;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serIn = 1'b0;
  logic syncIn = 1'b0;
  logic [1:0] rateSel = 2'd0;
  logic [31:0] dataOut;
  logic validOut, lockOut;
  logic [LW-1:0] lossCount;

  int nChecks = 0;
  int nFail = 0;
  int bitCnt = 0;
  bit padBit = 1'b0;

  always #5 clk = ~clk;

  link_word_aligner #(.SEARCH_BITS(SEARCH), .LOSS_W(LW)) u_link_word_aligner (
    .clk(clk), .rst(rst), .serIn(serIn), .syncIn(syncIn), .rateSel(rateSel),
    .dataOut(dataOut), .validOut(validOut), .lockOut(lockOut),
    .lossCount(lossCount)
  );

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int widthOf(input logic [1:0] r);
    return (r == 2'd0) ? 8 : (r == 2'd1) ? 16 : 32;
  endfunction

  // Behavioural reference model
  bit q[$];
  logic [1:0] mRate;
  int mPhase, mWin, mState, mOff, mLoss;
  bit mValid, mArmed;
  logic [31:0] mData;

  function automatic bit histBit(input int i);
    return (i < q.size()) ? q[i] : 1'b0;
  endfunction

  always @(posedge clk) begin
    int w;
    bit hit, em;
    mArmed = !rst;
    if (rst) begin
      mRate = rateSel; q.delete(); mPhase = 0; mWin = 0; mState = 0;
      mOff = 0; mLoss = 0; mValid = 0; mData = 0;
    end else if (rateSel != mRate) begin
      mRate = rateSel; q.delete(); mPhase = 0; mWin = 0; mState = 0;
      mValid = 0; mData = 0;
    end else begin
      w = widthOf(mRate);
      hit = (mWin > 0);
      for (int i = 0; i < 3 * w; i++) begin
        bit want;
        want = (i >= w && i < 2 * w);
        if (histBit(i) != want) hit = 0;
      end
      em = (mState == 2) && (mPhase == mOff);
      mValid = em;
      if (em) begin
        mData = 0;
        for (int i = 0; i < w; i++) mData[i] = histBit(i);
      end
      if (hit) begin
        if (mState == 0) begin mOff = mPhase; mState = 1; end
        else if (mState == 1) begin
          if (mPhase == mOff) mState = 2; else mOff = mPhase;
        end else if (mPhase != mOff) begin
          mState = 1; mOff = mPhase;
          if (mLoss < (1 << LW) - 1) mLoss++;
        end
      end
      q.push_front(serIn);
      if (q.size() > 96) void'(q.pop_back());
      mPhase = (mPhase + 1) % w;
      if (syncIn) mWin = SEARCH;
      else if (hit) mWin = 0;
      else if (mWin > 0) mWin--;
    end
  end

  always @(negedge clk) begin
    if (mArmed) begin
      check(validOut == mValid, "R6 valid", validOut, mValid);
      check(lockOut == (mState == 2), "R4 lock", lockOut, mState == 2);
      check(lossCount == LW'(mLoss), "R5 loss", lossCount, mLoss);
      if (mValid) check(dataOut == mData, "R6 data", dataOut, mData);
    end
  end

  task automatic sendBit(input bit b, input bit s);
    @(negedge clk);
    serIn = b;
    syncIn = s;
    @(posedge clk);
    bitCnt++;
  endtask

  task automatic pad();
    padBit = !padBit;
    sendBit(padBit, 1'b0);
  endtask

  task automatic rawMarker();
    int w;
    w = widthOf(rateSel);
    for (int i = 0; i < 3 * w; i++) sendBit(i >= w && i < 2 * w, 1'b0);
  endtask

  // Sync pulse, padding so the marker ends at offset off, then marker
  task automatic markerAt(input int off);
    int w, p;
    w = widthOf(rateSel);
    padBit = !padBit;
    sendBit(padBit, 1'b1);
    p = 0;
    while (p < 2 || (bitCnt % w) != off) begin pad(); p++; end
    rawMarker();
    pad(); pad();
    #1;
  endtask

  task automatic setRate(input logic [1:0] r);
    @(negedge clk);
    rateSel = r;
    syncIn = 1'b0;
    @(posedge clk);
    bitCnt = 0;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    syncIn = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    bitCnt = 0;
  endtask

  task automatic countValid(input int n, input int exp, input string req);
    int c;
    c = 0;
    for (int k = 0; k < n; k++) begin
      pad();
      #1;
      if (validOut) c++;
    end
    check(c == exp, req, c, exp);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    nFail++;
    $display("FAIL watchdog actual=1 expected=0");
    finishRun();
  end

  initial begin
    doReset();
    #1;
    check(lockOut == 0, "R1 lock after reset", lockOut, 0);
    check(validOut == 0, "R1 valid after reset", validOut, 0);
    check(lossCount == 0, "R1 loss after reset", lossCount, 0);

    // W=8
    markerAt(3);
    check(lockOut == 0, "R4 single match no lock", lockOut, 0);
    markerAt(3);
    check(lockOut == 1, "R4 second match locks", lockOut, 1);
    countValid(32, 4, "R2 R6 width 8 strobes");

    markerAt(5);
    check(lockOut == 0, "R5 other offset drops lock", lockOut, 0);
    check(lossCount == 1, "R5 loss counted", lossCount, 1);
    markerAt(5);
    check(lockOut == 1, "R5 relock at new offset", lockOut, 1);

    // R9: marker far outside the search window
    padBit = !padBit;
    sendBit(padBit, 1'b1);
    for (int k = 0; k < SEARCH + 40; k++) pad();
    rawMarker();
    pad(); pad();
    #1;
    check(lockOut == 1, "R9 late marker ignored lock", lockOut, 1);
    check(lossCount == 1, "R9 late marker ignored loss", lossCount, 1);

    // R7 / R2: W=16
    setRate(2'd1);
    check(lockOut == 0, "R7 rate change unlocks", lockOut, 0);
    check(lossCount == 1, "R7 loss kept", lossCount, 1);
    markerAt(7);
    check(lockOut == 0, "R7 first match after rate change", lockOut, 0);
    markerAt(7);
    check(lockOut == 1, "R3 lock at W=16", lockOut, 1);
    countValid(64, 4, "R2 R6 width 16 strobes");

    // W=32 via code 3 and code 2
    setRate(2'd3);
    markerAt(30);
    markerAt(30);
    check(lockOut == 1, "R3 lock at W=32", lockOut, 1);
    countValid(64, 2, "R2 R6 width 32 strobes");
    setRate(2'd2);
    check(lockOut == 0, "R7 code 3 to 2 unlocks", lockOut, 0);

    // R8 saturation at W=8
    setRate(2'd0);
    markerAt(1);
    markerAt(1);
    for (int i = 0; i < 20; i++) begin
      markerAt((i % 2 == 0) ? 2 : 1);
      markerAt((i % 2 == 0) ? 2 : 1);
    end
    check(lossCount == 4'hF, "R8 loss saturates", lossCount, 15);
    check(lockOut == 1, "R8 still relocks", lockOut, 1);

    doReset();
    #1;
    check(lockOut == 0, "R1 reset clears lock", lockOut, 0);
    check(lossCount == 0, "R1 reset clears loss", lossCount, 0);
    countValid(16, 0, "R6 no strobe unlocked");
    finishRun();
  end
endmodule